// File: doc/BRIEF.md
# Bus Turnaround and Inter-Packet Gap Timer

This block keeps time on a half-duplex serial bus between packets. Every interval is measured from the final transition of an end-of-packet to the first transition of the following packet. The counting unit is a quarter of a bit time, supplied as a four-times oversample enable. Because of this, the fractional response limits of 6.5 and 7.5 bit times become exact integer thresholds. After each end-of-packet the block holds off this side's transmitter for 2 bit times.

When the end-of-packet belongs to a packet that expects a reply, a response window opens. A reply that starts after the limit for the active role is flagged as late. If no reply starts by 17 bit times, a one-cycle timeout pulse is raised. That value lies inside the 16 to 18 bit-time band in which every listener must give up. After a timeout, a holdoff flag stays low until 18 bit times have passed since the end-of-packet, so the next token cannot go out before every downstream listener has timed out.

Packets between unrelated transactions have no maximum gap, so the window is opened only when the end-of-packet arrives together with the expect-response qualifier. The block does no packet decoding. It only consumes the end-of-packet and start-of-packet pulses that a line receiver produces.

Top module: `bus_turnaround_timer`

## Requirements
- R1: After reset, tx_allowed and holdoff_done are 1, and late_response and timeout are 0.
- R2: An eop_done pulse restarts the gap count at zero, and tx_allowed reads 0 from the next cycle. tx_allowed reads 1 again once 8 quarter-bit ticks (2 bit times) have been counted since that pulse.
- R3: With role_host = 1 (the responder is a device), a sop_seen pulse that arrives while the window is open and the count is 26 (6.5 bits) or less raises nothing. A pulse at a count above 26 gives a one-cycle late_response pulse in the following cycle.
- R4: With role_host = 0 (the responder is a host), the late limit is 30 ticks (7.5 bits). A response at count 30 is on time, and one at count 31 or more is late. The role is sampled on the sop_seen cycle.
- R5: An eop_done pulse with expect_resp = 0 opens no window. No late_response and no timeout follow, whatever the gap.
- R6: With the window open and no start of packet, timeout pulses for exactly one cycle. It pulses in the cycle in which the count becomes 68 ticks (17 bit times), and the window then closes.
- R7: A sop_seen pulse while the window is open closes the window, and no timeout follows for that gap.
- R8: holdoff_done drops to 0 in the cycle in which timeout is raised. It returns to 1 in the cycle in which the count reaches 72 ticks (18 bit times).
- R9: When eop_done and sop_seen arrive in the same cycle, the end-of-packet takes priority. The start is ignored, and the new window is governed by expect_resp.
- R10: The count advances only in cycles where tick_q is 1. It saturates at 72.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_q | input | 1 | Quarter-bit-time enable (4x oversample strobe) |
| eop_done | input | 1 | One-cycle pulse at the last transition of an end-of-packet |
| sop_seen | input | 1 | One-cycle pulse at the first transition of a new packet |
| expect_resp | input | 1 | Sampled with eop_done: a reply is expected to this packet |
| role_host | input | 1 | 1: this side is the host waiting on a device; 0: this side is a device waiting on the host |
| tx_allowed | output | 1 | Minimum inter-packet gap has elapsed |
| late_response | output | 1 | One-cycle pulse: reply started after the role limit |
| timeout | output | 1 | One-cycle pulse: no reply by 17 bit times |
| holdoff_done | output | 1 | Post-timeout holdoff has expired |

## Verification
Every output comes from a register that is updated on the edge which consumes the stimulus. The counter therefore reads N in the cycle after the Nth tick following eop_done. tx_allowed changes on that same cycle, and late_response appears one cycle after the sop_seen cycle. timeout and the fall of holdoff_done appear on the cycle in which the count becomes 68, and holdoff_done rises on the cycle in which it becomes 72. The bench drives inputs on the falling edge and advances its cycle model on the rising edge. It compares all four outputs on the next falling edge, so each expectation is checked exactly one register stage after its cause.

// File: rtl/tat_pkg.sv
package tat_pkg;

    // Default oversample ratio: ticks per bit time (must be even).
    localparam int unsigned TICKS_PER_BIT_DEF = 4;

    // Thresholds held in half-bit units so fractional limits stay exact.
    localparam int unsigned GAP_HALVES       = 4;   // 2 bit times
    localparam int unsigned DEV_RESP_HALVES  = 13;  // 6.5 bit times
    localparam int unsigned HOST_RESP_HALVES = 15;  // 7.5 bit times
    localparam int unsigned TMO_HALVES       = 34;  // 17 bit times
    localparam int unsigned HOLD_HALVES      = 36;  // 18 bit times

    function automatic int unsigned halves_to_ticks(int unsigned halves,
                                                    int unsigned tpb);
        return (halves * tpb) / 2;
    endfunction

    typedef enum logic {
        ROLE_DEVICE = 1'b0,
        ROLE_HOST   = 1'b1
    } role_e;

    // Events produced by the response window for one cycle.
    typedef struct packed {
        logic late;
        logic fire;
    } win_evt_t;

endpackage

// File: rtl/tat_gap_counter.sv
module tat_gap_counter #(
    parameter int unsigned CNT_W = 7,
    parameter int unsigned SAT_Q = 72,
    parameter int unsigned GAP_Q = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             eop,
    output logic [CNT_W-1:0] cnt,
    output logic             tx_ok
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_Q);
    localparam logic [CNT_W-1:0] GAP = CNT_W'(GAP_Q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= SAT;
        end else if (eop) begin
            cnt <= '0;
        end else if (tick && (cnt != SAT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tx_ok = (cnt >= GAP);

    // R2: an end-of-packet closes the transmit gate on the next cycle
    a_r2_eop_blocks_tx: assert property (@(posedge clk) disable iff (rst)
        eop |=> (!tx_ok && cnt == '0));

    // R10: without a tick the count does not move
    a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !eop) |=> $stable(cnt));

    // R10: the count never exceeds its saturation value
    a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
        cnt <= SAT);

endmodule

// File: rtl/tat_resp_window.sv
module tat_resp_window
    import tat_pkg::*;
#(
    parameter int unsigned CNT_W  = 7,
    parameter int unsigned DEV_Q  = 26,
    parameter int unsigned HOST_Q = 30,
    parameter int unsigned TMO_Q  = 68
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             eop,
    input  logic             sop,
    input  logic             expect_resp,
    input  role_e            role,
    input  logic [CNT_W-1:0] cnt,
    output win_evt_t         evt,
    output logic             late_pulse,
    output logic             timeout_pulse
);

    localparam logic [CNT_W-1:0] DEV_LIM  = CNT_W'(DEV_Q);
    localparam logic [CNT_W-1:0] HOST_LIM = CNT_W'(HOST_Q);
    localparam logic [CNT_W-1:0] TMO_PRE  = CNT_W'(TMO_Q - 1);
    localparam logic [CNT_W-1:0] TMO_AT   = CNT_W'(TMO_Q);

    logic             armed;
    logic [CNT_W-1:0] limit;

    // A host waits on a device (tighter limit); a device waits on the host.
    assign limit = (role == ROLE_HOST) ? DEV_LIM : HOST_LIM;

    always_comb begin
        evt.late = armed && !eop && sop && (cnt > limit);
        evt.fire = armed && !eop && !sop && tick && (cnt == TMO_PRE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed         <= 1'b0;
            late_pulse    <= 1'b0;
            timeout_pulse <= 1'b0;
        end else begin
            late_pulse    <= evt.late;
            timeout_pulse <= evt.fire;
            if (eop) begin
                armed <= expect_resp;
            end else if (armed && sop) begin
                armed <= 1'b0;
            end else if (evt.fire) begin
                armed <= 1'b0;
            end
        end
    end

    // R6: timeout is a single-cycle pulse
    a_r6_timeout_single: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |=> !timeout_pulse);

    // R6: timeout coincides with the count reaching 17 bit times
    a_r6_timeout_at_limit: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |-> (cnt == TMO_AT));

    // R7: a start of packet inside the window suppresses the timeout
    a_r7_sop_cancels: assert property (@(posedge clk) disable iff (rst)
        (armed && sop && !eop) |=> !timeout_pulse);

    // R5: an unexpected-reply end-of-packet raises no window event next cycle
    a_r5_unarmed_quiet: assert property (@(posedge clk) disable iff (rst)
        (eop && !expect_resp) |=> (!late_pulse && !timeout_pulse));

    // R3: late_response is a single-cycle pulse
    a_r3_late_single: assert property (@(posedge clk) disable iff (rst)
        late_pulse |=> !late_pulse);

endmodule

// File: rtl/tat_holdoff.sv
module tat_holdoff #(
    parameter int unsigned CNT_W  = 7,
    parameter int unsigned HOLD_Q = 72
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             eop,
    input  logic [CNT_W-1:0] cnt,
    input  logic             fire,
    output logic             holdoff_done
);

    localparam logic [CNT_W-1:0] HOLD_PRE = CNT_W'(HOLD_Q - 1);
    localparam logic [CNT_W-1:0] HOLD_AT  = CNT_W'(HOLD_Q);

    logic pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (fire) begin
            pending <= 1'b1;
        end else if (pending && tick && !eop && (cnt == HOLD_PRE)) begin
            pending <= 1'b0;
        end
    end

    assign holdoff_done = !pending;

    // R8: holdoff releases only when 18 bit times have been counted
    a_r8_release_point: assert property (@(posedge clk) disable iff (rst)
        $rose(holdoff_done) |-> (cnt == HOLD_AT));

    // R8: a timeout event starts the holdoff
    a_r8_fire_blocks: assert property (@(posedge clk) disable iff (rst)
        fire |=> !holdoff_done);

endmodule

// File: rtl/bus_turnaround_timer.sv
module bus_turnaround_timer
    import tat_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = TICKS_PER_BIT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_q,
    input  logic eop_done,
    input  logic sop_seen,
    input  logic expect_resp,
    input  logic role_host,
    output logic tx_allowed,
    output logic late_response,
    output logic timeout,
    output logic holdoff_done
);

    localparam int unsigned GAP_Q  = halves_to_ticks(GAP_HALVES, TICKS_PER_BIT);
    localparam int unsigned DEV_Q  = halves_to_ticks(DEV_RESP_HALVES, TICKS_PER_BIT);
    localparam int unsigned HOST_Q = halves_to_ticks(HOST_RESP_HALVES, TICKS_PER_BIT);
    localparam int unsigned TMO_Q  = halves_to_ticks(TMO_HALVES, TICKS_PER_BIT);
    localparam int unsigned HOLD_Q = halves_to_ticks(HOLD_HALVES, TICKS_PER_BIT);
    localparam int unsigned CNT_W  = $clog2(HOLD_Q + 1);

    logic [CNT_W-1:0] gap_cnt;
    win_evt_t         win_evt;
    role_e            role;

    assign role = role_e'(role_host);

    tat_gap_counter #(
        .CNT_W (CNT_W),
        .SAT_Q (HOLD_Q),
        .GAP_Q (GAP_Q)
    ) u_gap (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_q),
        .eop   (eop_done),
        .cnt   (gap_cnt),
        .tx_ok (tx_allowed)
    );

    tat_resp_window #(
        .CNT_W  (CNT_W),
        .DEV_Q  (DEV_Q),
        .HOST_Q (HOST_Q),
        .TMO_Q  (TMO_Q)
    ) u_win (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick_q),
        .eop           (eop_done),
        .sop           (sop_seen),
        .expect_resp   (expect_resp),
        .role          (role),
        .cnt           (gap_cnt),
        .evt           (win_evt),
        .late_pulse    (late_response),
        .timeout_pulse (timeout)
    );

    tat_holdoff #(
        .CNT_W  (CNT_W),
        .HOLD_Q (HOLD_Q)
    ) u_hold (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick_q),
        .eop          (eop_done),
        .cnt          (gap_cnt),
        .fire         (win_evt.fire),
        .holdoff_done (holdoff_done)
    );

    // R8: whenever timeout is reported the holdoff is in force
    a_r8_timeout_holds: assert property (@(posedge clk) disable iff (rst)
        timeout |-> !holdoff_done);

    // R6/R3: a reply cannot be both late and missing in the same cycle
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(timeout && late_response));

endmodule

// File: tb/bus_turnaround_timer_test.sv
module bus_turnaround_timer_test;

    localparam int CLK_PERIOD = 10;
    // Expected thresholds in quarter-bit ticks, from the requirements.
    localparam int GAP_T  = 8;
    localparam int DEV_T  = 26;
    localparam int HOST_T = 30;
    localparam int TMO_T  = 68;
    localparam int HOLD_T = 72;

    logic clk = 1'b0;
    logic rst, tick_q, eop_done, sop_seen, expect_resp, role_host;
    logic tx_allowed, late_response, timeout, holdoff_done;

    int vectors = 0;
    int errors  = 0;

    // Reference state kept by the bench
    int m_cnt;
    bit m_armed, m_pend, e_late, e_to;

    bus_turnaround_timer uut (
        .clk (clk), .rst (rst), .tick_q (tick_q), .eop_done (eop_done),
        .sop_seen (sop_seen), .expect_resp (expect_resp), .role_host (role_host),
        .tx_allowed (tx_allowed), .late_response (late_response),
        .timeout (timeout), .holdoff_done (holdoff_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int late_limit(bit host);
        return host ? DEV_T : HOST_T;
    endfunction

    task automatic model_step(bit t, bit e, bit s, bit x, bit r);
        int old = m_cnt;
        e_late = 1'b0;
        e_to   = 1'b0;
        if (e) begin
            m_cnt   = 0;
            m_armed = x;
        end else begin
            if (m_armed && s) begin
                e_late  = (old > late_limit(r));
                m_armed = 1'b0;
            end else if (m_armed && t && old == TMO_T - 1) begin
                e_to    = 1'b1;
                m_armed = 1'b0;
            end
            if (m_pend && t && old == HOLD_T - 1) m_pend = 1'b0;
            if (e_to) m_pend = 1'b1;
            if (t && old < HOLD_T) m_cnt = old + 1;
        end
    endtask

    task automatic check(string req);
        bit xtx = (m_cnt >= GAP_T);
        bit xho = !m_pend;
        vectors++;
        if (tx_allowed !== xtx || late_response !== e_late ||
            timeout !== e_to || holdoff_done !== xho) begin
            errors++;
            $display("FAIL %s cnt=%0d actual tx=%b late=%b to=%b hold=%b expected tx=%b late=%b to=%b hold=%b",
                     req, m_cnt, tx_allowed, late_response, timeout, holdoff_done,
                     xtx, e_late, e_to, xho);
        end
    endtask

    // Drive at the falling edge, model at the rising edge, check at the next falling edge.
    task automatic cycle(bit t, bit e, bit s, bit x, bit r, string req);
        tick_q = t; eop_done = e; sop_seen = s; expect_resp = x; role_host = r;
        @(posedge clk);
        model_step(t, e, s, x, r);
        @(negedge clk);
        check(req);
    endtask

    task automatic ticks(int n, bit r, string req);
        for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 1'b0, 1'b0, r, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int seen_to;
        void'($urandom(32'h1d5e_ed01));
        rst = 1'b1; tick_q = 0; eop_done = 0; sop_seen = 0; expect_resp = 0; role_host = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = HOLD_T; m_armed = 0; m_pend = 0; e_late = 0; e_to = 0;
        check("R1 reset state");

        // R2: gap closes on EOP and reopens after 8 ticks
        cycle(1, 1, 0, 0, 1, "R2 eop");
        ticks(10, 1, "R2 gap");

        // R10: no-tick cycles hold the count
        cycle(0, 1, 0, 0, 1, "R10 eop");
        ticks(5, 1, "R10 ticks");
        for (int i = 0; i < 20; i++) cycle(0, 0, 0, 0, 1, "R10 idle");
        ticks(4, 1, "R10 resume");

        // R3: host role, reply at 26 on time, at 27 late
        cycle(1, 1, 0, 1, 1, "R3 eop");
        ticks(26, 1, "R3 wait");
        cycle(0, 0, 1, 0, 1, "R3 on-time");
        cycle(0, 0, 0, 0, 1, "R3 after");
        cycle(1, 1, 0, 1, 1, "R3 eop");
        ticks(27, 1, "R3 wait");
        cycle(0, 0, 1, 0, 1, "R3 late start");
        cycle(0, 0, 0, 0, 1, "R3 late pulse");

        // R4: device role, 30 on time, 31 late
        cycle(1, 1, 0, 1, 0, "R4 eop");
        ticks(30, 0, "R4 wait");
        cycle(0, 0, 1, 0, 0, "R4 on-time");
        cycle(0, 0, 0, 0, 0, "R4 after");
        cycle(1, 1, 0, 1, 0, "R4 eop");
        ticks(31, 0, "R4 wait");
        cycle(0, 0, 1, 0, 0, "R4 late start");
        cycle(0, 0, 0, 0, 0, "R4 late pulse");

        // R5: no reply expected, long gap, no timeout
        seen_to = 0;
        cycle(1, 1, 0, 0, 1, "R5 eop");
        for (int i = 0; i < 80; i++) begin
            cycle(1, 0, (i == 40), 0, 1, "R5 quiet");
            if (timeout || late_response) seen_to++;
        end
        vectors++;
        if (seen_to != 0) begin
            errors++;
            $display("FAIL R5 actual events=%0d expected=0", seen_to);
        end

        // R6 and R8: timeout at 68, holdoff until 72
        seen_to = 0;
        cycle(1, 1, 0, 1, 1, "R6 eop");
        for (int i = 0; i < 80; i++) begin
            cycle(1, 0, 0, 0, 1, "R6/R8 run");
            if (timeout) seen_to++;
        end
        vectors++;
        if (seen_to != 1) begin
            errors++;
            $display("FAIL R6 actual pulses=%0d expected=1", seen_to);
        end

        // R7: reply at tick 60 cancels the timeout
        cycle(1, 1, 0, 1, 1, "R7 eop");
        ticks(60, 1, "R7 wait");
        cycle(1, 0, 1, 0, 1, "R7 sop");
        ticks(15, 1, "R7 no timeout");

        // R9: EOP and SOP together, EOP wins, window armed
        cycle(1, 1, 1, 1, 1, "R9 both");
        ticks(75, 1, "R9 timeout still due");

        // Random mix
        for (int i = 0; i < 5000; i++) begin
            cycle(($urandom % 4) != 0, ($urandom % 90) == 0, ($urandom % 60) == 0,
                  ($urandom % 3) != 0, ($urandom % 2) == 1, "R2/R3/R4/R6/R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule